// File: doc/BRIEF.md
# Past-Time Temporal Property Monitor

This block watches a serial stream of bus events and judges, event by event, whether a past-time temporal property still holds. Each event arrives as a one-hot identifier with a valid strobe. Two of the identifier bits are mapped to the propositions A and B. The history of the stream is summarised in a handful of state bits: "always A", "once B", "previously B" and "B, then A ever since". These bits change only when an event is presented. A clock cycle with no event leaves them untouched.

The property is fixed at elaboration by a parameter. It is one of four: "A implies once B" (for example, a grant must follow some earlier or simultaneous request), "always A", "A since B", and "A implies previously B". All history bits advance together in one parallel update. A verdict that depends on a history bit that includes the current event is therefore computed from that bit's next value and not from its stored value. The verdict is registered together with the state. After every event, exactly one of two single-cycle pulses is raised: one for a violation, one for a validation. A downstream recovery handler can act on these pulses.

Top module: `ptltl_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, the monitor sets `verdict_o` to 1 and both pulses to 0 on that edge. It also returns the history to its initial values: always-A true, once-B false, previously-B false, since false.
- R2: A clock edge with `ev_valid_i` low changes no history bit. It also leaves `verdict_o` at its old value and drives both pulses low, whatever `ev_id_i` carries.
- R3: On the edge that accepts a valid event, the monitor raises exactly one of `violation_o` and `validation_o` for one cycle. `validation_o` is raised when the new verdict is 1, and `violation_o` when it is 0.
- R4: With FORMULA = FML_IMPL_ONCE, the verdict is (not A) or B or (B was true at some earlier event since reset). A request in the current event counts.
- R5: With FORMULA = FML_ALWAYS, the verdict is 1 only if A held at every event since reset, the current one included. Once the verdict is 0, it stays 0 until reset.
- R6: With FORMULA = FML_SINCE, the verdict is 1 when B holds now. It is also 1 when A holds now and the since value was 1 after the previous event. Otherwise it is 0.
- R7: With FORMULA = FML_IMPL_PREV, the verdict is (not A) or (B held at the previous event). At the first event after reset, "previously" is false.
- R8: A is true for an event exactly when bit A_EV of `ev_id_i` is set (default bit 0). B is true exactly when bit B_EV is set (default bit 1). Any other one-hot code is an event at which both propositions are false.
- R9: A reset in mid-stream erases all history. The next event is judged as if it were the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid_i | input | 1 | An event is present this cycle |
| ev_id_i | input | NUM_EVENTS | One-hot event identifier |
| verdict_o | output | 1 | Property value after the latest event |
| violation_o | output | 1 | One-cycle pulse: latest event made the property false |
| validation_o | output | 1 | One-cycle pulse: latest event made the property true |

## Verification
The checker assumes that every valid event carries exactly one set identifier bit. It also assumes that the mapped A and B bits are distinct, so A and B are never true at the same event. The stimulus keeps to this: it uses only single-bit codes, and it gives an idle cycle a stale code without the strobe. The history-dependent properties, a sticky request for the implication and a sticky failure for "always", are checked against flags that the checker rebuilds from the ports. Those flags are cleared by the same reset that the checker watches.

// File: rtl/ptltl_pkg.sv
package ptltl_pkg;

    typedef enum logic [1:0] {
        FML_IMPL_ONCE = 2'd0,
        FML_ALWAYS    = 2'd1,
        FML_SINCE     = 2'd2,
        FML_IMPL_PREV = 2'd3
    } formula_e;

    typedef struct packed {
        logic a;
        logic b;
    } props_t;

    typedef struct packed {
        logic alw;    // A at every step so far
        logic once;   // B at some step so far
        logic prev;   // B at the last step
        logic since;  // B, then A continuously
    } hist_t;

    localparam hist_t HIST_INIT = '{alw: 1'b1, once: 1'b0, prev: 1'b0, since: 1'b0};

    // Parallel next-state of every history bit for one event.
    function automatic hist_t hist_step(hist_t s, props_t p);
        hist_t n;
        n.alw   = p.a & s.alw;
        n.once  = p.b | s.once;
        n.prev  = p.b;
        n.since = p.b | (p.a & s.since);
        return n;
    endfunction

endpackage

// File: rtl/ptltl_prop_map.sv
module ptltl_prop_map #(
    parameter int NUM_EVENTS = 4,
    parameter int A_EV       = 0,
    parameter int B_EV       = 1
) (
    input  logic [NUM_EVENTS-1:0] ev_id,
    output ptltl_pkg::props_t     props
);
    localparam logic [NUM_EVENTS-1:0] A_MASK = NUM_EVENTS'(1) << A_EV;
    localparam logic [NUM_EVENTS-1:0] B_MASK = NUM_EVENTS'(1) << B_EV;

    always_comb begin
        props.a = |(ev_id & A_MASK);
        props.b = |(ev_id & B_MASK);
    end
endmodule

// File: rtl/ptltl_hist.sv
module ptltl_hist
    import ptltl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    input  props_t props,
    output hist_t  hist_q,
    output hist_t  hist_n
);
    always_comb hist_n = hist_step(hist_q, props);

    always_ff @(posedge clk) begin
        if (rst)       hist_q <= HIST_INIT;
        else if (step) hist_q <= hist_n;
    end
endmodule

// File: rtl/ptltl_verdict.sv
module ptltl_verdict
    import ptltl_pkg::*;
#(
    parameter formula_e FORMULA = FML_IMPL_ONCE
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic a_now,
    input  logic alw_n,
    input  logic once_n,
    input  logic since_n,
    input  logic prev_q,
    output logic verdict,
    output logic viol,
    output logic vald
);
    logic v_step;

    // Bits that include the current event come from the next state;
    // "previously" reads the stored bit.
    generate
        if (FORMULA == FML_IMPL_ONCE) begin : g_once
            always_comb v_step = ~a_now | once_n;
        end else if (FORMULA == FML_ALWAYS) begin : g_alw
            always_comb v_step = alw_n;
        end else if (FORMULA == FML_SINCE) begin : g_since
            always_comb v_step = since_n;
        end else begin : g_prev
            always_comb v_step = ~a_now | prev_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= 1'b1;
            viol    <= 1'b0;
            vald    <= 1'b0;
        end else if (step) begin
            verdict <= v_step;
            viol    <= ~v_step;
            vald    <= v_step;
        end else begin
            viol    <= 1'b0;
            vald    <= 1'b0;
        end
    end
endmodule

// File: rtl/ptltl_monitor.sv
module ptltl_monitor
    import ptltl_pkg::*;
#(
    parameter int       NUM_EVENTS = 4,
    parameter int       A_EV       = 0,
    parameter int       B_EV       = 1,
    parameter formula_e FORMULA    = FML_IMPL_ONCE
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ev_valid_i,
    input  logic [NUM_EVENTS-1:0] ev_id_i,
    output logic                  verdict_o,
    output logic                  violation_o,
    output logic                  validation_o
);
    props_t props;
    hist_t  hist_q;
    hist_t  hist_n;

    ptltl_prop_map #(
        .NUM_EVENTS(NUM_EVENTS),
        .A_EV      (A_EV),
        .B_EV      (B_EV)
    ) u_map (
        .ev_id(ev_id_i),
        .props(props)
    );

    ptltl_hist u_hist (
        .clk   (clk),
        .rst   (rst),
        .step  (ev_valid_i),
        .props (props),
        .hist_q(hist_q),
        .hist_n(hist_n)
    );

    ptltl_verdict #(
        .FORMULA(FORMULA)
    ) u_verdict (
        .clk    (clk),
        .rst    (rst),
        .step   (ev_valid_i),
        .a_now  (props.a),
        .alw_n  (hist_n.alw),
        .once_n (hist_n.once),
        .since_n(hist_n.since),
        .prev_q (hist_q.prev),
        .verdict(verdict_o),
        .viol   (violation_o),
        .vald   (validation_o)
    );
endmodule

// File: rtl/ptltl_monitor_chk.sv
module ptltl_monitor_chk
    import ptltl_pkg::*;
#(
    parameter int       NUM_EVENTS = 4,
    parameter int       B_EV       = 1,
    parameter formula_e FORMULA    = FML_IMPL_ONCE
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ev_valid_i,
    input logic [NUM_EVENTS-1:0] ev_id_i,
    input logic                  verdict_o,
    input logic                  violation_o,
    input logic                  validation_o
);
    logic rst_d = 1'b0;
    logic req_seen;
    logic fail_seen;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            req_seen  <= 1'b0;
            fail_seen <= 1'b0;
        end else begin
            if (ev_valid_i && ev_id_i[B_EV]) req_seen <= 1'b1;
            if (violation_o) fail_seen <= 1'b1;
        end
    end

    // R1: state seen on the edge after a reset edge
    always_ff @(posedge clk) begin
        if (rst_d) begin
            p_reset_out_r1: assert (verdict_o && !violation_o && !validation_o)
                else $error("reset output wrong");
        end
    end

    // R8: input assumption, one-hot identifier with every event
    p_onehot_id_r8: assert property (@(posedge clk) disable iff (rst)
        ev_valid_i |-> $onehot(ev_id_i));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ev_valid_i |=> (!violation_o && !validation_o && $stable(verdict_o)));

    p_one_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        ev_valid_i |=> (violation_o ^ validation_o));

    p_pulse_agree_r3: assert property (@(posedge clk) disable iff (rst)
        (validation_o |-> verdict_o) and (violation_o |-> !verdict_o));

    generate
        if (FORMULA == FML_IMPL_ONCE) begin : g_once_chk
            p_req_sticky_r4: assert property (@(posedge clk) disable iff (rst)
                (ev_valid_i && req_seen) |=> validation_o);
        end else if (FORMULA == FML_ALWAYS) begin : g_alw_chk
            p_fail_sticky_r5: assert property (@(posedge clk) disable iff (rst)
                (ev_valid_i && fail_seen) |=> violation_o);
        end
    endgenerate
endmodule

bind ptltl_monitor ptltl_monitor_chk #(
    .NUM_EVENTS(NUM_EVENTS),
    .B_EV      (B_EV),
    .FORMULA   (FORMULA)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_valid_i  (ev_valid_i),
    .ev_id_i     (ev_id_i),
    .verdict_o   (verdict_o),
    .violation_o (violation_o),
    .validation_o(validation_o)
);

// File: tb/ptltl_monitor_tb.sv
`timescale 1ns/1ps
module ptltl_monitor_tb;
    import ptltl_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_valid = 1'b0;
    logic [3:0] ev_id = 4'b0000;
    logic [3:0] verd, viol, vald;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    // index 0: A implies once B (u_dut), 1: always A, 2: A since B, 3: A implies previously B
    ptltl_monitor #(.FORMULA(FML_IMPL_ONCE)) u_dut (
        .clk(clk), .rst(rst), .ev_valid_i(ev_valid), .ev_id_i(ev_id),
        .verdict_o(verd[0]), .violation_o(viol[0]), .validation_o(vald[0]));
    ptltl_monitor #(.FORMULA(FML_ALWAYS)) u_alw (
        .clk(clk), .rst(rst), .ev_valid_i(ev_valid), .ev_id_i(ev_id),
        .verdict_o(verd[1]), .violation_o(viol[1]), .validation_o(vald[1]));
    ptltl_monitor #(.FORMULA(FML_SINCE)) u_snc (
        .clk(clk), .rst(rst), .ev_valid_i(ev_valid), .ev_id_i(ev_id),
        .verdict_o(verd[2]), .violation_o(viol[2]), .validation_o(vald[2]));
    ptltl_monitor #(.FORMULA(FML_IMPL_PREV)) u_prv (
        .clk(clk), .rst(rst), .ev_valid_i(ev_valid), .ev_id_i(ev_id),
        .verdict_o(verd[3]), .violation_o(viol[3]), .validation_o(vald[3]));

    // {rst, valid, id[3:0], expected verdict: once, always, since, prev}
    // A = 0001, B = 0010, unmapped = 0100
    localparam int NV = 14;
    localparam logic [9:0] VEC [NV] = '{
        10'b1_0_0000_1111,  // 0  reset (R1)
        10'b0_1_0001_0100,  // 1  A first step
        10'b0_1_0010_1011,  // 2  B
        10'b0_1_0001_1011,  // 3  A
        10'b0_0_0001_1011,  // 4  idle with stale A (R2)
        10'b0_1_0001_1010,  // 5  A
        10'b0_1_0100_1001,  // 6  unmapped event (R8)
        10'b0_1_0010_1011,  // 7  B
        10'b1_0_0000_1111,  // 8  reset mid-stream (R9)
        10'b0_1_0001_0100,  // 9  A after reset: no history (R9)
        10'b0_1_0001_0100,  // 10 A
        10'b0_1_0010_1011,  // 11 B
        10'b0_1_0010_1011,  // 12 B
        10'b0_0_0010_1011   // 13 idle with stale B (R2)
    };

    string ftag [4] = '{"R4", "R5", "R6", "R7"};

    function automatic string row_tag(int r);
        case (r)
            0:       return "R1";
            4, 13:   return "R2";
            6:       return "R8";
            8, 9:    return "R9";
            default: return "-";
        endcase
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        for (int r = 0; r < NV; r++) begin
            rst      = VEC[r][9];
            ev_valid = VEC[r][8];
            ev_id    = VEC[r][7:4];
            @(posedge clk);
            #1;
            for (int k = 0; k < 4; k++) begin
                logic e_v, e_viol, e_vald;
                logic stepped;
                e_v     = VEC[r][3-k];
                stepped = !VEC[r][9] && VEC[r][8];
                e_viol  = stepped && !e_v;
                e_vald  = stepped && e_v;
                n_chk++;
                if (verd[k] !== e_v) begin
                    n_bad++;
                    $display("FAIL %s/%s row %0d unit %0d verdict actual=%b expected=%b",
                             ftag[k], row_tag(r), r, k, verd[k], e_v);
                end
                n_chk++;
                if (viol[k] !== e_viol || vald[k] !== e_vald) begin
                    n_bad++;
                    $display("FAIL R3/%s row %0d unit %0d pulses actual=%b%b expected=%b%b",
                             row_tag(r), r, k, viol[k], vald[k], e_viol, e_vald);
                end
            end
        end
        // R2: extra idle cycles keep pulses low
        ev_valid = 1'b0;
        ev_id    = 4'b0001;
        repeat (3) begin
            @(posedge clk);
            #1;
            n_chk++;
            if (viol !== 4'b0000 || vald !== 4'b0000 || verd !== 4'b1101) begin
                n_bad++;
                $display("FAIL R2 idle actual=%b/%b/%b expected=0000/0000/1101",
                         viol, vald, verd);
            end
        end
        finish_run();
    end
endmodule